// File: doc/BRIEF.md
# Dual-Read Single-Write Program Register File

This block holds the program registers of a small processor core. Two read ports each take a register identifier and return that register's word combinationally. One write port takes an identifier and a data word and stores the word on the rising clock edge. The identifier is the storage address. Both reads and the write can all be active in the same cycle.

Identifiers are wider than the register count needs. Any identifier at or above the register count is a null identifier, and no access takes place. A read with a null identifier returns zero. A write with a null identifier changes nothing. Because of this, an instruction that has no source or no destination can drive the null identifier on that port and needs no separate enable line.

There is no forwarding from the write port to the read ports. A read of the register that is being written in the same cycle returns the value held before the edge. A synchronous, active-low reset clears every register.

Top module: `rf_three_port`

## Requirements
- R1: After a cycle with `rst_n` low at a rising clock edge, every register reads back as zero on both read ports.
- R2: With `wr_id` in the range 0 to 7 at a rising edge (and `rst_n` high), `wr_data` is stored in that register, and reading that identifier afterwards returns it.
- R3: Each read port returns the contents of the register named by its own identifier, combinationally and independently of the other port, including when both name the same register.
- R4: A read identifier from 8 to 15 (the null identifiers) returns the value 0 on that port.
- R5: A write with `wr_id` from 8 to 15 leaves all eight registers unchanged.
- R6: While a write to register k is pending, a read of k in the same cycle returns the value k held before the edge. The new value appears only after the edge.
- R7: A write to register k leaves every other register unchanged. Register 0 is an ordinary storage location and is not tied to zero.
- R8: Reset has priority over a simultaneous valid write: the register targeted by that write still reads zero after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears all registers |
| rd_a_id | input | 4 | Register identifier for read port A (8..15 = null) |
| rd_a_data | output | 32 | Word read through port A, zero for a null identifier |
| rd_b_id | input | 4 | Register identifier for read port B (8..15 = null) |
| rd_b_data | output | 32 | Word read through port B, zero for a null identifier |
| wr_id | input | 4 | Register identifier for the write port (8..15 = no write) |
| wr_data | input | 32 | Word stored at the next rising edge |

## Verification
A fault inside the storage cannot be seen until some read port names the affected register. So the bench reads every register through both ports after each kind of write, and it sweeps all 256 pairs of read identifiers. A wrong write decode is visible one cycle after the edge, either as a word in the wrong register or as a register that lost its value. A fault in the null decode or in the read mux shows up in the same cycle, because reads are purely combinational. A hidden bypass would be detected by checking the same-cycle read during every write.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int unsigned RF_DATA_W   = 32;
  localparam int unsigned RF_NUM_REGS = 8;
  localparam int unsigned RF_ID_W     = 4;

  // An identifier names a real register only when it is below the count.
  function automatic logic rf_id_selects(input int unsigned id,
                                         input int unsigned nregs);
    return id < nregs;
  endfunction

endpackage

// File: rtl/rf_id_decode.sv
module rf_id_decode #(
  parameter int unsigned NUM_REGS = rf_pkg::RF_NUM_REGS,
  parameter int unsigned ID_W     = rf_pkg::RF_ID_W,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ID_W-1:0]     id,
  output logic                hit,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] sel
);

  assign hit = rf_pkg::rf_id_selects(int'(id), NUM_REGS);
  assign idx = id[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = hit && (int'(id) == g);
  end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DATA_W   = rf_pkg::RF_DATA_W,
  parameter int unsigned NUM_REGS = rf_pkg::RF_NUM_REGS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_sel[g]) begin
        regs_q[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W   = rf_pkg::RF_DATA_W,
  parameter int unsigned NUM_REGS = rf_pkg::RF_NUM_REGS,
  parameter int unsigned ID_W     = rf_pkg::RF_ID_W,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ID_W-1:0]                  id,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
  output logic                             hit,
  output logic [DATA_W-1:0]                data
);

  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] sel_unused;

  rf_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_dec (
    .id  (id),
    .hit (hit),
    .idx (idx),
    .sel (sel_unused)
  );

  always_comb begin
    data = '0;
    if (hit) begin
      data = regs_q[idx];
    end
  end

endmodule

// File: rtl/rf_three_port.sv
module rf_three_port #(
  parameter int unsigned DATA_W   = rf_pkg::RF_DATA_W,
  parameter int unsigned NUM_REGS = rf_pkg::RF_NUM_REGS,
  parameter int unsigned ID_W     = rf_pkg::RF_ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  // Named internal events, observed by the bound checker.
  logic                            wr_hit;
  logic [IDX_W-1:0]                wr_idx;
  logic [NUM_REGS-1:0]             wr_sel;
  logic                            rd_a_hit;
  logic                            rd_b_hit;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  rf_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_wr_dec (
    .id  (wr_id),
    .hit (wr_hit),
    .idx (wr_idx),
    .sel (wr_sel)
  );

  rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_rd_a (
    .id     (rd_a_id),
    .regs_q (regs_q),
    .hit    (rd_a_hit),
    .data   (rd_a_data)
  );

  rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_rd_b (
    .id     (rd_b_id),
    .regs_q (regs_q),
    .hit    (rd_b_hit),
    .data   (rd_b_data)
  );

endmodule

// File: rtl/rf_three_port_chk.sv
module rf_three_port_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ID_W     = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ID_W-1:0]     rd_a_id,
  input logic [DATA_W-1:0]   rd_a_data,
  input logic [ID_W-1:0]     rd_b_id,
  input logic [DATA_W-1:0]   rd_b_data,
  input logic [ID_W-1:0]     wr_id,
  input logic [DATA_W-1:0]   wr_data,
  input logic                wr_hit,
  input logic [NUM_REGS-1:0] wr_sel,
  input logic                rd_a_hit
);

  logic hist_ok = 1'b0;
  always_ff @(posedge clk) hist_ok <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && !$past(rst_n)) |-> (rd_a_data == '0 && rd_b_data == '0)); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(rst_n) && $past(wr_hit) && rd_a_id == $past(wr_id))
      |-> rd_a_data == $past(wr_data)); // R2

  AST_WRITE_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R2

  AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_b_id) >= NUM_REGS) |-> rd_b_data == '0); // R4

  AST_NULL_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(rst_n) && !$past(wr_hit) && rd_a_hit && $past(rd_a_id) == rd_a_id)
      |-> $stable(rd_a_data)); // R5

  AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(rst_n) && rd_a_hit && $past(rd_a_id) == rd_a_id
       && $past(wr_id) != rd_a_id) |-> $stable(rd_a_data)); // R7

endmodule

bind rf_three_port rf_three_port_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_a_id   (rd_a_id),
  .rd_a_data (rd_a_data),
  .rd_b_id   (rd_b_id),
  .rd_b_data (rd_b_data),
  .wr_id     (wr_id),
  .wr_data   (wr_data),
  .wr_hit    (wr_hit),
  .wr_sel    (wr_sel),
  .rd_a_hit  (rd_a_hit)
);

// File: tb/rf_three_port_tb.sv
module rf_three_port_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_id, rd_b_id, wr_id;
  logic [31:0] rd_a_data, rd_b_data, wr_data;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [31:0] model [8];

  always #5 clk = ~clk;

  rf_three_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
    .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
    .wr_id(wr_id), .wr_data(wr_data)
  );

  function automatic logic [31:0] pat(input int unsigned i, input int unsigned seed);
    return (seed * 32'h9E37_79B9) ^ (i * 32'h0101_0101) ^ 32'hA500_005A;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [3:0] id);
    return (id < 4'd8) ? model[id[2:0]] : 32'h0;
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs settle just after a falling edge; checks sample 1 ns later.
  task automatic read_both(input logic [3:0] a, input logic [3:0] b, input string req);
    rd_a_id = a; rd_b_id = b;
    #1;
    cmp(req, rd_a_data, expect_rd(a));
    cmp(req, rd_b_data, expect_rd(b));
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 8; i++) begin
      read_both(4'(i), 4'(7 - i), req);
    end
  endtask

  // Writes with a same-cycle read of the target, which must show the old word (R6).
  task automatic write_reg(input logic [3:0] id, input logic [31:0] d);
    @(negedge clk);
    wr_id = id; wr_data = d;
    read_both(id, id, "R6");
    @(negedge clk);
    if (rst_n && id < 4'd8) model[id[2:0]] = d;
    wr_id = 4'hF; wr_data = 32'h0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_a_id = 4'd0; rd_b_id = 4'd0;
    // R8: valid write held during reset must be dropped.
    wr_id = 4'd3; wr_data = 32'hDEAD_BEEF;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; wr_id = 4'hF;
    read_both(4'd3, 4'd3, "R8");
    read_all("R1");

    // R2/R6: fill every register, register 0 included (R7).
    for (int i = 0; i < 8; i++) write_reg(4'(i), pat(i, 1));
    read_all("R2");

    // R3/R4: every pair of read identifiers, null range included.
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        read_both(4'(a), 4'(b), (a >= 8 || b >= 8) ? "R4" : "R3");
      end
    end

    // R5: null-identifier writes change nothing.
    for (int w = 8; w < 16; w++) begin
      write_reg(4'(w), pat(w, 7));
      read_all("R5");
    end

    // R7: single writes leave the others intact.
    for (int k = 0; k < 8; k++) begin
      write_reg(4'(k), pat(k, 20 + k));
      read_all("R7");
    end

    // R6 again with data that differs from the held word in every bit.
    write_reg(4'd5, ~model[5]);
    read_both(4'd5, 4'd9, "R6");

    // R1: second reset after the file holds data.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    read_all("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule